// File: doc/BRIEF.md
# Adaptive Reference-Rate Range Controller

This block sits next to a counter-based frequency synthesizer. In that synthesizer, one counter measures each input period against a counting reference. The result lands in a register, and a second counter counts the register value back down against a second reference. When the stored count is small, integer truncation makes the synthesized frequency coarse. When it is large, the counters risk overrun. This controller keeps the measured count inside a programmable window. It does so by speeding up or slowing down both counting references together.

Both references are clock-enable strobes derived from the system clock. Each comes from its own prescaler, and all prescalers share one power-of-two exponent. Each time a new measurement is written, the controller compares it against a low and a high threshold. It then moves the shared exponent by at most one step. A smaller exponent means faster references and larger counts. A larger exponent means slower references and smaller counts. Every reference is rescaled by the same factor, so the ratio between the two reference rates, and with it the synthesized output ratio, is unchanged. Only the measurement resolution moves.

Top module: `refrate_range_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rate_exp` takes the value 4 (parameter `INIT_EXP`) and every bit of `ref_stb` is 0. In the first cycle after the first edge with `rst_n` high, every strobe is 1.
- R2: When `meas_valid` is 1, the thresholds are consistent, `meas_count < thr_low` and `rate_exp > 0`, then `rate_exp` is one lower after that edge.
- R3: When `meas_valid` is 1, the thresholds are consistent, `meas_count > thr_high` and `rate_exp < 7`, then `rate_exp` is one higher after that edge.
- R4: The exponent saturates. It stays at 0 when a faster step is requested at 0, and it stays at 7 when a slower step is requested at 7.
- R5: The exponent is unchanged after any edge where `meas_valid` is 0, or where `thr_low <= meas_count <= thr_high`. Both bounds are inclusive.
- R6: The thresholds are consistent only when `thr_high >= 4 * thr_low`. Otherwise, a measurement leaves the exponent unchanged.
- R7: Each strobe is a single-cycle pulse that recurs every 2^`rate_exp` system clocks. At exponent 0 it is high every cycle.
- R8: All strobes are identical in every cycle. In the cycle in which a new exponent first appears, all prescalers restart, so every strobe is 1 in that cycle.
- R9: The exponent changes by at most one step, and only after an edge where `meas_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_valid | input | 1 | One-cycle pulse: a new count was written to the synthesizer register |
| meas_count | input | CW (16) | Count held in the synthesizer register |
| thr_low | input | CW (16) | Lower window bound |
| thr_high | input | CW (16) | Upper window bound |
| rate_exp | output | EW (3) | Shared prescaler exponent |
| ref_stb | output | NREF (2) | Clock-enable strobes, one per counting reference |

## Verification
The window logic is driven through a walk of measurements. The walk includes values just below, at, and just above each threshold, which separates strict from inclusive comparison. It also runs the exponent into both rails, which shows whether saturation holds or the value wraps. Two threshold pairs sit just on either side of the four-to-one guard, which tells a working guard from a missing or off-by-one one. Strobe spacing is measured at exponents 4, 1 and 0, and each exponent change is checked for a restart pulse. Together these expose a wrong prescaler mask, a stale period after a change, and strobes that drift apart.

// File: rtl/rrc_pkg.sv
// Shared types for the reference-rate range controller.
package rrc_pkg;
    // Decision taken on one measurement.
    typedef enum logic [1:0] {
        ADJ_HOLD   = 2'd0,
        ADJ_FASTER = 2'd1,
        ADJ_SLOWER = 2'd2
    } adj_t;
endpackage

// File: rtl/rrc_window.sv
// Window comparator.
// Classifies a freshly written count against the low/high thresholds.
// Assumes: the thresholds are usable only when high >= 4*low; otherwise it holds.
module rrc_window
    import rrc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          valid,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output adj_t          adj
);
    localparam int GW = CW + 2;

    logic thr_ok;

    // Threshold consistency: upper bound at least four times the lower one.
    always_comb begin
        thr_ok = {2'b00, hi} >= {lo, 2'b00};
    end

    // Strict comparison on both sides; equality stays in the window.
    always_comb begin
        adj = ADJ_HOLD;
        if (valid && thr_ok) begin
            if (count < lo)      adj = ADJ_FASTER;
            else if (count > hi) adj = ADJ_SLOWER;
        end
    end

    logic [GW-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/rrc_exponent.sv
// Shared exponent register.
// Steps at most once per decision and saturates at 0 and 2**EW-1.
// Assumes: the decision arrives as a one-cycle request.
module rrc_exponent
    import rrc_pkg::*;
#(
    parameter int EW       = 3,
    parameter int INIT_EXP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  adj_t          adj,
    output logic [EW-1:0] exp_q,
    output logic          exp_load
);
    localparam logic [EW-1:0] EXP_MAX = {EW{1'b1}};
    localparam logic [EW-1:0] EXP_RST = EW'(INIT_EXP);

    logic [EW-1:0] exp_nxt;

    // Next exponent with saturation at both rails.
    always_comb begin
        exp_nxt = exp_q;
        case (adj)
            ADJ_FASTER: if (exp_q != '0)      exp_nxt = exp_q - 1'b1;
            ADJ_SLOWER: if (exp_q != EXP_MAX) exp_nxt = exp_q + 1'b1;
            default:    exp_nxt = exp_q;
        endcase
        exp_load = (exp_nxt != exp_q);
    end

    // Exponent state.
    always_ff @(posedge clk) begin
        if (!rst_n) exp_q <= EXP_RST;
        else        exp_q <= exp_nxt;
    end
endmodule

// File: rtl/rrc_prescaler.sv
// Power-of-two strobe generator.
// Emits a one-cycle enable every 2**exp clocks and restarts its phase on load.
// Assumes: load is high on the edge where exp takes a new value.
module rrc_prescaler #(
    parameter int EW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] exp_q,
    input  logic          load,
    output logic          stb
);
    localparam int PW = (2 ** EW) - 1;

    logic [PW-1:0] cnt;
    logic [PW-1:0] mask;
    logic          live;

    // Terminal mask for the current exponent.
    always_comb begin
        mask = ~({PW{1'b1}} << exp_q);
    end

    // Running flag: strobes stay low during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // Phase counter: wraps inside the mask and restarts on exponent change.
    always_ff @(posedge clk) begin
        if (!rst_n || !live || load) cnt <= '0;
        else                         cnt <= (cnt + 1'b1) & mask;
    end

    // Strobe at phase zero.
    always_comb begin
        stb = live && (cnt == '0);
    end
endmodule

// File: rtl/refrate_range_ctl.sv
// Adaptive reference-rate range controller (top).
// Keeps a measured count inside a window by rescaling all counting
// references with one shared power-of-two exponent.
// Assumes: meas_valid pulses once per measured input period.
module refrate_range_ctl
    import rrc_pkg::*;
#(
    parameter int CW       = 16,
    parameter int EW       = 3,
    parameter int NREF     = 2,
    parameter int INIT_EXP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            meas_valid,
    input  logic [CW-1:0]   meas_count,
    input  logic [CW-1:0]   thr_low,
    input  logic [CW-1:0]   thr_high,
    output logic [EW-1:0]   rate_exp,
    output logic [NREF-1:0] ref_stb
);
    adj_t adj;
    logic exp_load;

    rrc_window #(.CW(CW)) u_win (
        .valid (meas_valid),
        .count (meas_count),
        .lo    (thr_low),
        .hi    (thr_high),
        .adj   (adj)
    );

    rrc_exponent #(.EW(EW), .INIT_EXP(INIT_EXP)) u_exp (
        .clk      (clk),
        .rst_n    (rst_n),
        .adj      (adj),
        .exp_q    (rate_exp),
        .exp_load (exp_load)
    );

    // One prescaler per counting reference, all on the shared exponent.
    for (genvar g = 0; g < NREF; g++) begin : g_ref
        rrc_prescaler #(.EW(EW)) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .exp_q (rate_exp),
            .load  (exp_load),
            .stb   (ref_stb[g])
        );
    end
endmodule

// File: rtl/rrc_checker.sv
// Property checker for refrate_range_ctl, attached by bind.
// Assumes: properties are only meaningful one cycle after reset release.
module rrc_checker #(
    parameter int CW   = 16,
    parameter int EW   = 3,
    parameter int NREF = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            meas_valid,
    input logic [CW-1:0]   meas_count,
    input logic [CW-1:0]   thr_low,
    input logic [CW-1:0]   thr_high,
    input logic [EW-1:0]   rate_exp,
    input logic [NREF-1:0] ref_stb
);
    localparam logic [EW-1:0] EXP_MAX = {EW{1'b1}};

    logic settled;
    logic consistent;

    // Marks cycles whose history lies entirely after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) settled <= 1'b0;
        else        settled <= 1'b1;
    end

    always_comb begin
        consistent = (32'(thr_high) >= (32'(thr_low) * 4));
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        meas_valid && consistent && meas_count < thr_low && rate_exp != '0
        |=> rate_exp == $past(rate_exp) - 1'b1);  // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        meas_valid && consistent && meas_count > thr_high && rate_exp != EXP_MAX
        |=> rate_exp == $past(rate_exp) + 1'b1);  // R3
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        meas_valid && meas_count < thr_low && rate_exp == '0 |=> rate_exp == '0);  // R4
    AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        meas_valid && meas_count > thr_high && rate_exp == EXP_MAX |=> rate_exp == EXP_MAX);  // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        !meas_valid |=> $stable(rate_exp));  // R5
    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        meas_valid && !consistent |=> $stable(rate_exp));  // R6
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        ref_stb[0] && rate_exp != '0 |=> !ref_stb[0] || !$stable(rate_exp));  // R7
    AST_SAME_RATE: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        ref_stb == {NREF{ref_stb[0]}});  // R8
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        !$stable(rate_exp) |-> ref_stb[0]);  // R8
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n || !settled)
        !$stable(rate_exp) |-> $past(meas_valid));  // R9
endmodule

bind refrate_range_ctl rrc_checker #(.CW(CW), .EW(EW), .NREF(NREF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas_count (meas_count),
    .thr_low    (thr_low),
    .thr_high   (thr_high),
    .rate_exp   (rate_exp),
    .ref_stb    (ref_stb)
);

// File: tb/sim_refrate_range_ctl.sv
// Bench: table walk of measurements, then directed reset, period and hold tests.
module sim_refrate_range_ctl;
    localparam int CW = 16;
    localparam int EW = 3;
    localparam int NREF = 2;
    localparam int NVEC = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            meas_valid = 1'b0;
    logic [CW-1:0]   meas_count = '0;
    logic [CW-1:0]   thr_low = 16'd100;
    logic [CW-1:0]   thr_high = 16'd1000;
    logic [EW-1:0]   rate_exp;
    logic [NREF-1:0] ref_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    refrate_range_ctl #(.CW(CW), .EW(EW), .NREF(NREF), .INIT_EXP(4)) u0 (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_count(meas_count),
        .thr_low(thr_low), .thr_high(thr_high), .rate_exp(rate_exp), .ref_stb(ref_stb)
    );

    // Entry fields: [51:36] low, [35:20] high, [19:4] count, [3:0] expected exponent.
    localparam logic [51:0] VEC [NVEC] = '{
        {16'd100, 16'd1000, 16'd50,    4'd3},  // R2 below low
        {16'd100, 16'd1000, 16'd100,   4'd3},  // R5 equal low
        {16'd100, 16'd1000, 16'd1000,  4'd3},  // R5 equal high
        {16'd100, 16'd1000, 16'd1001,  4'd4},  // R3 just above high
        {16'd100, 16'd1000, 16'd65535, 4'd5},  // R3
        {16'd100, 16'd1000, 16'd5000,  4'd6},  // R3
        {16'd100, 16'd1000, 16'd5000,  4'd7},  // R3
        {16'd100, 16'd1000, 16'd5000,  4'd7},  // R4 ceiling
        {16'd100, 16'd399,  16'd5,     4'd7},  // R6 guard fails
        {16'd100, 16'd400,  16'd5,     4'd6},  // R6 guard boundary passes
        {16'd100, 16'd400,  16'd0,     4'd5},
        {16'd100, 16'd400,  16'd0,     4'd4},
        {16'd100, 16'd400,  16'd0,     4'd3},
        {16'd100, 16'd400,  16'd0,     4'd2},
        {16'd100, 16'd400,  16'd0,     4'd1},
        {16'd100, 16'd400,  16'd0,     4'd0},
        {16'd100, 16'd400,  16'd0,     4'd0},  // R4 floor
        {16'd0,   16'd0,    16'd1,     4'd1}   // R3 zero thresholds
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Present one measurement for one cycle; return at the next falling edge.
    task automatic measure(input logic [CW-1:0] lo, input logic [CW-1:0] hi,
                           input logic [CW-1:0] cnt, input logic vld);
        @(negedge clk);
        thr_low = lo; thr_high = hi; meas_count = cnt; meas_valid = vld;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    // Count falling edges until the next strobe and compare with 2**e.
    task automatic period(input int e, input string req);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
            check(ref_stb[1] == ref_stb[0], "R8 strobes equal", ref_stb[1], ref_stb[0]);
        end while (!ref_stb[0] && k < 300);
        check(k == (1 << e), req, k, 1 << e);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int prev;
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(rate_exp == 3'd4, "R1 reset exponent", rate_exp, 4);
        check(ref_stb == '0, "R1 strobes low in reset", ref_stb, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ref_stb == '1, "R1 first strobe after reset", ref_stb, 3);
        // R7: period at the reset exponent.
        period(4, "R7 period at exponent 4");
        period(4, "R7 second period at exponent 4");

        // R5: out-of-window counts without a valid pulse are ignored.
        for (int i = 0; i < 4; i++) measure(16'd100, 16'd1000, 16'd0, 1'b0);
        check(rate_exp == 3'd4, "R5 no valid no change", rate_exp, 4);

        // Table walk: R2 R3 R4 R5 R6 R8 R9.
        prev = 4;
        for (int i = 0; i < NVEC; i++) begin
            measure(VEC[i][51:36], VEC[i][35:20], VEC[i][19:4], 1'b1);
            check(rate_exp == EW'(VEC[i][3:0]), "R2/R3/R4/R5/R6/R9 table entry",
                  rate_exp, VEC[i][3:0]);
            if (int'(VEC[i][3:0]) != prev)
                check(ref_stb == '1, "R8 restart on change", ref_stb, 3);
            prev = int'(VEC[i][3:0]);
        end

        // R7: short period at exponent 1, then continuous at exponent 0.
        period(1, "R7 period at exponent 1");
        period(1, "R7 repeat period at exponent 1");
        measure(16'd100, 16'd1000, 16'd3, 1'b1);
        check(rate_exp == 3'd0, "R2 step to zero", rate_exp, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(ref_stb == '1, "R7 exponent 0 strobe every cycle", ref_stb, 3);
        end

        // R9: one step per measurement even for a far-out count.
        measure(16'd100, 16'd1000, 16'd65535, 1'b1);
        check(rate_exp == 3'd1, "R9 single step", rate_exp, 1);

        // R1: reset again mid-run restores the initial exponent.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(rate_exp == 3'd4, "R1 reapplied reset", rate_exp, 4);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule